// File: doc/BRIEF.md
# Serial Receiver with Break and Framing-Error Status

This block is the receive side of an asynchronous serial port. It watches the receive line, using a 16x oversampling tick that the surrounding logic supplies. It checks each start bit at its midpoint and builds frames of 8 data bits, least significant bit first, with one stop bit and no parity. Each received byte goes into a 16-entry FIFO together with a one-bit tag. The tag is set when the stop bit was sampled at space (0), which is a framing error.

Two status flags sit next to the FIFO. The framing-error flag is read-only. It shows the tag of the entry that the next data read will return, so it changes as entries are popped. The break flag is sticky. It sets when a frame with a framing error is followed by more received data that is all zero and also lacks a stop bit, with the line never going back to mark in between. During a break the block stops filling the FIFO with zero bytes. It starts storing again once the line is back at mark. To clear the break flag, software must first read the status while the flag is 1 and then write 0 to it.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, st_brk and st_fer are 0, fifo_cnt is 0 and rx_ovr is 0.
- R2: The receiver assembles 8N1 frames (start bit 0, data LSB first, stop bit 1). Bytes leave the FIFO in arrival order. rx_byte shows the head byte, and a one-cycle pulse on dr_rd pops it.
- R3: A frame whose stop bit is sampled as 0 is still stored, and its entry carries a framing-error tag.
- R4: st_fer equals the tag of the head entry and follows it as entries are popped. It is 0 while the FIFO is empty.
- R5: st_brk sets when a frame that has a framing error is followed, with no mark on the line in between, by a frame that has data 0x00 and also has a framing error.
- R6: The framing-error frame that leads into a break is stored. The frames received while the break lasts are not stored. Storing starts again with the first frame that begins after the line has returned to mark and the receiver has gone idle.
- R7: st_brk clears only when a status write with st_wbrk=0 follows a status read (st_rd) that returned st_brk=1. Any status write in between cancels the pending clear.
- R8: A status write of 0 that no status read returning 1 has come before leaves st_brk at 1.
- R9: When a frame arrives while the FIFO holds 16 entries, that frame is dropped, rx_ovr pulses for one cycle, and the stored entries are unchanged.
- R10: A dr_rd pulse while the FIFO is empty has no effect. The next frame received is stored and read back correctly.
- R11: A low pulse on the line that is shorter than half a bit is rejected at the start-bit check and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle at 1 |
| st_rd | input | 1 | Status read strobe |
| st_wr | input | 1 | Status write strobe |
| st_wbrk | input | 1 | Break-flag value written by st_wr |
| dr_rd | input | 1 | Data read strobe, pops the head entry |
| rx_byte | output | 8 | Head data byte, 0 when empty |
| st_brk | output | 1 | Sticky break flag |
| st_fer | output | 1 | Framing-error tag of the head entry |
| fifo_cnt | output | 5 | Number of stored entries |
| rx_ovr | output | 1 | One-cycle pulse when a frame is dropped because the FIFO is full |

## Verification
A frame is decided at the middle of its stop bit. After that, the entry needs two clocks (the frame-valid register, then the FIFO write) before fifo_cnt, rx_byte and st_fer reflect it. The bench therefore samples only after the whole stop bit plus an idle gap. A status write or a pop shows on st_brk, st_fer and fifo_cnt one clock later, so the bench drops the strobe at one falling edge and reads the outputs at the next. A break needs a second zero frame before st_brk can rise, so the bench holds the line at space for three frame times and checks the flag and the FIFO count only after the line has returned to mark and the receiver has gone idle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} rx_phase_t;

    typedef struct packed {
        logic       fe;
        logic [7:0] data;
    } rx_entry_t;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    output logic          rx_lvl,
    output logic          rx_idle,
    output logic          frm_vld,
    output logic          frm_fe,
    output logic [DW-1:0] frm_data
);
    localparam int CNTW = $clog2(OSR);
    localparam int IDXW = $clog2(DW);
    localparam logic [CNTW-1:0] MID  = CNTW'(OSR / 2 - 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(OSR - 1);
    localparam logic [IDXW-1:0] TOP  = IDXW'(DW - 1);

    typedef struct packed {
        rx_phase_t       ph;
        logic [CNTW-1:0] cnt;
        logic [IDXW-1:0] idx;
        logic [DW-1:0]   sh;
        logic [1:0]      sync;
        logic            vld;
        logic            fe;
    } smp_t;

    smp_t q, d;
    logic line;

    assign line = q.sync[1];

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.sync = {q.sync[0], rxd};
        if (tick) begin
            case (q.ph)
                PH_IDLE: begin
                    if (!line) begin
                        d.ph  = PH_START;
                        d.cnt = '0;
                    end
                end
                PH_START: begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.ph  = line ? PH_IDLE : PH_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {line, q.sh[DW-1:1]};
                        if (q.idx == TOP) d.ph = PH_STOP;
                        else              d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.vld = 1'b1;
                        d.fe  = ~line;
                        d.ph  = PH_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph   <= PH_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sh   <= '0;
            q.sync <= 2'b11;
            q.vld  <= 1'b0;
            q.fe   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rx_lvl   = line;
    assign rx_idle  = (q.ph == PH_IDLE);
    assign frm_vld  = q.vld;
    assign frm_fe   = q.fe;
    assign frm_data = q.sh;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  wr_ent,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } ptr_t;

    ptr_t q, d;
    rx_entry_t mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (q.cnt != FULLV);
        do_pop  = pop && (q.cnt != '0);
        d       = q;
        d.ovr   = push && (q.cnt == FULLV);
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wr_ent;
    end

    assign head  = mem[q.rp];
    assign count = q.cnt;
    assign ovr   = q.ovr;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_lvl,
    input  logic          rx_idle,
    input  logic          frm_vld,
    input  logic          frm_fe,
    input  logic [DW-1:0] frm_data,
    input  logic          st_rd,
    input  logic          st_wr,
    input  logic          st_wbrk,
    output logic          push,
    output logic          brk,
    output logic          act
);
    typedef struct packed {
        logic brk;
        logic act;
        logic arm;
        logic after_fe;
    } bk_t;

    bk_t  q, d;
    logic detect;

    always_comb begin
        detect = frm_vld && frm_fe && q.after_fe && !q.act && (frm_data == '0);
        push   = frm_vld && !q.act && !detect;
        d      = q;

        if (rx_lvl)         d.after_fe = 1'b0;
        if (push && frm_fe) d.after_fe = 1'b1;

        if (detect)                          d.act = 1'b1;
        else if (q.act && rx_idle && rx_lvl) d.act = 1'b0;

        if (st_wr)               d.arm = 1'b0;
        else if (st_rd && q.brk) d.arm = 1'b1;

        if (st_wr && !st_wbrk && q.arm) d.brk = 1'b0;
        if (detect)                     d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign brk = q.brk;
    assign act = q.act;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       os_tick,
    input  logic                       rxd,
    input  logic                       st_rd,
    input  logic                       st_wr,
    input  logic                       st_wbrk,
    input  logic                       dr_rd,
    output logic [7:0]                 rx_byte,
    output logic                       st_brk,
    output logic                       st_fer,
    output logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    output logic                       rx_ovr
);
    localparam int DW = 8;

    logic          lvl_w, idle_w, frm_vld_w, frm_fe_w, push_w, act_w;
    logic [DW-1:0] frm_data_w;
    rx_entry_t     wr_ent, head_w;

    uart_rx_sampler #(.OSR(OSR), .DW(DW)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
        .rx_lvl(lvl_w), .rx_idle(idle_w), .frm_vld(frm_vld_w),
        .frm_fe(frm_fe_w), .frm_data(frm_data_w)
    );

    uart_rx_brk #(.DW(DW)) u_brk (
        .clk(clk), .rst_n(rst_n), .rx_lvl(lvl_w), .rx_idle(idle_w),
        .frm_vld(frm_vld_w), .frm_fe(frm_fe_w), .frm_data(frm_data_w),
        .st_rd(st_rd), .st_wr(st_wr), .st_wbrk(st_wbrk),
        .push(push_w), .brk(st_brk), .act(act_w)
    );

    assign wr_ent.fe   = frm_fe_w;
    assign wr_ent.data = frm_data_w;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_w), .wr_ent(wr_ent),
        .pop(dr_rd), .head(head_w), .count(fifo_cnt), .ovr(rx_ovr)
    );

    assign st_fer  = (fifo_cnt != '0) && head_w.fe;
    assign rx_byte = (fifo_cnt != '0) ? head_w.data : 8'h00;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       st_brk,
    input logic                       st_fer,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    input logic                       rx_ovr,
    input logic                       st_wr,
    input logic                       st_wbrk,
    input logic                       dr_rd,
    input logic                       push,
    input logic                       brk_act,
    input logic                       frm_vld
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    a_r8_brk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        st_brk && !(st_wr && !st_wbrk) |=> st_brk);

    a_r7_clear_by_write0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_brk) |-> $past(st_wr && !st_wbrk));

    a_r5_brk_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_brk) |-> $past(frm_vld));

    a_r6_no_push_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |-> !push);

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FULLV);

    a_r9_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> $past(fifo_cnt) == FULLV);

    a_r4_fer_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt == '0 |-> !st_fer);

    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt == '0 && dr_rd && !push |=> fifo_cnt == '0);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_brk(st_brk), .st_fer(st_fer),
    .fifo_cnt(fifo_cnt), .rx_ovr(rx_ovr), .st_wr(st_wr), .st_wbrk(st_wbrk),
    .dr_rd(dr_rd), .push(push_w), .brk_act(act_w), .frm_vld(frm_vld_w)
);

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       st_rd = 1'b0, st_wr = 1'b0, st_wbrk = 1'b0, dr_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       st_brk, st_fer, rx_ovr;
    logic [4:0] fifo_cnt;

    int n_chk = 0, n_err = 0, ovr_seen = 0;
    logic [8:0] mq[$];

    uart_rx_status u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .st_rd(st_rd), .st_wr(st_wr), .st_wbrk(st_wbrk), .dr_rd(dr_rd),
        .rx_byte(rx_byte), .st_brk(st_brk), .st_fer(st_fer),
        .fifo_cnt(fifo_cnt), .rx_ovr(rx_ovr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n && rx_ovr) ovr_seen++;

    initial begin
        @(posedge rst_n);
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    function automatic logic [8:0] exp_entry(logic [7:0] dat, logic stopv);
        return {~stopv, dat};
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] dat, logic stopv);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = dat[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stopv;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic idle(int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_chk(string req);
        logic [8:0] e;
        e = mq.pop_front();
        check(req, int'(rx_byte), int'(e[7:0]));
        check("R4", int'(st_fer), int'(e[8]));
        dr_rd = 1'b1;
        @(negedge clk);
        dr_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe_rd();
        st_rd = 1'b1;
        @(negedge clk);
        st_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe_wr(logic v);
        st_wr = 1'b1;
        st_wbrk = v;
        @(negedge clk);
        st_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic sv;
        int nf;
        void'($urandom(32'h5eed1234));
        repeat (4) @(negedge clk);
        check("R1 brk", int'(st_brk), 0);
        check("R1 fer", int'(st_fer), 0);
        check("R1 cnt", int'(fifo_cnt), 0);
        check("R1 ovr", int'(rx_ovr), 0);
        rst_n = 1'b1;
        idle(100);

        // R10: pop on empty is ignored
        dr_rd = 1'b1; @(negedge clk); dr_rd = 1'b0; @(negedge clk);
        check("R10 cnt", int'(fifo_cnt), 0);
        send(8'h81, 1'b1); mq.push_back(exp_entry(8'h81, 1'b1)); idle(BITCLK);
        check("R10 cnt after frame", int'(fifo_cnt), 1);
        pop_chk("R10 data");

        // R11: short glitch rejected
        rxd = 1'b0; repeat (12) @(negedge clk); idle(1000);
        check("R11 cnt", int'(fifo_cnt), 0);

        // R3 R4: framing error without break, tag follows head
        send(8'h33, 1'b0); mq.push_back(exp_entry(8'h33, 1'b0)); idle(200);
        send(8'h44, 1'b1); mq.push_back(exp_entry(8'h44, 1'b1)); idle(BITCLK);
        check("R3 cnt", int'(fifo_cnt), 2);
        check("R5 no brk", int'(st_brk), 0);
        pop_chk("R3 data");
        pop_chk("R2 data");
        check("R4 empty fer", int'(st_fer), 0);

        // R5 R6: break
        send(8'h00, 1'b0); mq.push_back(exp_entry(8'h00, 1'b0));
        rxd = 1'b0; repeat (3 * 10 * BITCLK) @(negedge clk);
        idle(1000);
        check("R5 brk set", int'(st_brk), 1);
        check("R6 one entry", int'(fifo_cnt), 1);
        send(8'h5A, 1'b1); mq.push_back(exp_entry(8'h5A, 1'b1)); idle(BITCLK);
        check("R6 resume", int'(fifo_cnt), 2);
        pop_chk("R6 first");
        pop_chk("R6 after");

        // R8 R7: clear handshake
        strobe_wr(1'b0);
        check("R8 write0 no read", int'(st_brk), 1);
        strobe_rd(); strobe_wr(1'b1); strobe_wr(1'b0);
        check("R7 disarmed", int'(st_brk), 1);
        strobe_rd(); strobe_wr(1'b0);
        check("R7 cleared", int'(st_brk), 0);

        // R9: overflow
        nf = ovr_seen;
        for (int i = 0; i < 17; i++) begin
            b = 8'($urandom);
            send(b, 1'b1);
            if (i < 16) mq.push_back(exp_entry(b, 1'b1));
            idle(BITCLK);
        end
        check("R9 cnt full", int'(fifo_cnt), 16);
        check("R9 ovr pulses", ovr_seen - nf, 1);
        for (int i = 0; i < 16; i++) pop_chk("R9 contents");

        // R2 R3: random bursts
        for (int r = 0; r < 4; r++) begin
            nf = 1 + int'($urandom % 8);
            for (int i = 0; i < nf; i++) begin
                b  = 8'($urandom);
                sv = ($urandom % 6) != 0;
                send(b, sv);
                mq.push_back(exp_entry(b, sv));
                idle(2 * BITCLK);
            end
            check("R2 burst cnt", int'(fifo_cnt), nf);
            for (int i = 0; i < nf; i++) pop_chk("R2 random");
        end
        check("R5 brk stays clear", int'(st_brk), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule